// File: doc/BRIEF.md
# Frame-Buffer Sobel Edge Engine

This block turns a stored grayscale frame into an edge-strength frame. Source pixels are unsigned 8-bit values in raster order in a dual-port pixel RAM. The engine fetches them one at a time through the RAM's read port. It keeps the two previous rows in internal line stores, so a full 3x3 neighbourhood is ready for every pixel. From that neighbourhood it forms the horizontal and vertical gradients, takes the square root of the sum of their squares, and writes one result byte per pixel into a result region of the same RAM.

Work begins with a one-cycle start pulse. The engine then runs through the whole frame on its own and raises done after its final write, so a display reader can fetch the finished result region. Frame width, frame height and the base address of the result region are parameters. The defaults are 160 columns by 120 rows, with the result region placed directly after the source region.

Top module: `sobel_frame_engine`

## Requirements
- R1: While rst is high, and in the first cycle after it, busy, done, rd_en and wr_en are all 0. A reset in the middle of a frame abandons that frame.
- R2: A start pulse while idle makes busy read 1 in the next cycle. A start pulse while busy is ignored: the frame in progress completes with exactly one write per result address.
- R3: Every source address from 0 to COLS*ROWS-1 is read exactly once per frame, and rd_en is never raised for an address outside that range. Read data is used one cycle after rd_en.
- R4: The result at interior position (r, c) is floor(sqrt(gx*gx + gy*gy)). Here gx is the sum of the right-hand column of the 3x3 window, weighted 1,2,1 from top to bottom, minus the left-hand column weighted the same way. gy is the top row, weighted 1,2,1 from left to right, minus the bottom row weighted the same way.
- R5: A magnitude above 255 is written as 255.
- R6: Positions in row 0, row ROWS-1, column 0 and column COLS-1 are written as 0.
- R7: done rises after the final result write and stays high until the next accepted start. In the cycle after that start it is 0. done and busy are never high together.
- R8: Result position (r, c) is written at address OUT_BASE + r*COLS + c. No write lands outside the result region, and a read and a write never happen in the same cycle.
- R9: Each result address is written exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a frame when idle |
| busy | output | 1 | High while a frame is being processed |
| done | output | 1 | High from the end of a frame until the next start |
| rd_en | output | 1 | Read request to the pixel RAM |
| rd_addr | output | ADDR_W | Source pixel address |
| rd_data | input | 8 | Pixel returned one cycle after rd_en |
| wr_en | output | 1 | Write request to the pixel RAM |
| wr_addr | output | ADDR_W | Result pixel address |
| wr_data | output | 8 | Result pixel value |

## Verification
The engine is run on six whole frames. A flat field must give an all-zero interior. A vertical step and a horizontal step separate the two kernels and their signs; the horizontal step is tall enough to drive the magnitude into the 255 clamp. A checkerboard makes the opposing kernel weights cancel, which catches a wrong weight or a wrong tap position. A linear ramp and a diagonal step give non-saturated values in which gx and gy are both nonzero, which exposes errors in the square-root rounding and in the pairing of rows with columns. Every frame also counts how often each address is read and written, which catches misaligned read data, wrong write addresses and a start that wrongly restarts a running frame.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int GRAD_W = PIX_W + 3;
    localparam int ABS_W  = GRAD_W - 1;
    localparam int SQ_W   = 2 * GRAD_W - 1;
    localparam int ROOT_W = (SQ_W + 1) / 2;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [2:0][2:0][PIX_W-1:0] win_t;
    typedef logic signed [GRAD_W-1:0] grad_t;

    typedef struct packed {
        logic on_edge;
        logic has_window;
        logic final_px;
    } scan_flags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_TAKE,
        ST_EDGE_WR,
        ST_ROOT_GO,
        ST_ROOT_WAIT,
        ST_MAG_WR,
        ST_NEXT
    } eng_state_t;

    function automatic grad_t widen(input pix_t p);
        return grad_t'({{(GRAD_W - PIX_W){1'b0}}, p});
    endfunction

    function automatic logic [ABS_W-1:0] grad_abs(input grad_t g);
        grad_t m;
        m = (g < 0) ? -g : g;
        return m[ABS_W-1:0];
    endfunction

    function automatic pix_t clamp_root(input logic [ROOT_W-1:0] r);
        if (|r[ROOT_W-1:PIX_W])
            return '1;
        return r[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/sobel_scan.sv
module sobel_scan
    import sobel_pkg::*;
#(
    parameter int COLS  = 160,
    parameter int ROWS  = 120,
    parameter int COL_W = $clog2(COLS),
    parameter int IDX_W = $clog2(COLS * ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic [IDX_W-1:0] idx,
    output scan_flags_t      flags
);
    localparam int ROW_W = $clog2(ROWS);

    logic [ROW_W-1:0] row;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row <= '0;
            col <= '0;
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
            if (col == COL_W'(COLS - 1)) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    always_comb begin
        flags.on_edge    = (row == '0) || (row == ROW_W'(ROWS - 1)) ||
                           (col == '0) || (col == COL_W'(COLS - 1));
        flags.has_window = (row >= ROW_W'(2)) && (col >= COL_W'(2));
        flags.final_px   = (idx == IDX_W'(COLS * ROWS - 1));
    end

endmodule

// File: rtl/sobel_window.sv
module sobel_window
    import sobel_pkg::*;
#(
    parameter int COLS  = 160,
    parameter int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [COL_W-1:0] col,
    input  pix_t             px,
    output win_t             win
);
    pix_t line_near [0:COLS-1];
    pix_t line_far  [0:COLS-1];

    always_ff @(posedge clk) begin
        if (shift_en) begin
            line_far[col]  <= line_near[col];
            line_near[col] <= px;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                win[g] <= '0;
            end else if (shift_en) begin
                win[g][0] <= win[g][1];
                win[g][1] <= win[g][2];
                if (g == 0)
                    win[g][2] <= line_far[col];
                else if (g == 1)
                    win[g][2] <= line_near[col];
                else
                    win[g][2] <= px;
            end
        end
    end

endmodule

// File: rtl/sobel_grad.sv
module sobel_grad
    import sobel_pkg::*;
(
    input  win_t            win,
    output logic [SQ_W-1:0] sumsq
);
    grad_t lhs, rhs, top, bot, gx, gy;
    logic [ABS_W-1:0] ax, ay;

    always_comb begin
        lhs = widen(win[0][0]) + widen(win[1][0]) + widen(win[1][0]) + widen(win[2][0]);
        rhs = widen(win[0][2]) + widen(win[1][2]) + widen(win[1][2]) + widen(win[2][2]);
        top = widen(win[0][0]) + widen(win[0][1]) + widen(win[0][1]) + widen(win[0][2]);
        bot = widen(win[2][0]) + widen(win[2][1]) + widen(win[2][1]) + widen(win[2][2]);
        gx  = rhs - lhs;
        gy  = top - bot;
        ax  = grad_abs(gx);
        ay  = grad_abs(gy);
        sumsq = SQ_W'(ax) * SQ_W'(ax) + SQ_W'(ay) * SQ_W'(ay);
    end

endmodule

// File: rtl/sobel_isqrt.sv
module sobel_isqrt
    import sobel_pkg::*;
#(
    parameter int IN_W = SQ_W,
    parameter int K    = (IN_W + 1) / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic [IN_W-1:0] radicand,
    output logic [K-1:0]    root,
    output logic            valid
);
    localparam int OP_W  = 2 * K;
    localparam int REM_W = K + 1;
    localparam int TRY_W = K + 3;
    localparam int CNT_W = $clog2(K + 1);

    logic [OP_W-1:0]  bits_left;
    logic [REM_W-1:0] rem;
    logic [CNT_W-1:0] steps;
    logic             running;
    logic [TRY_W-1:0] rem_next, trial;

    always_comb begin
        rem_next = {rem, bits_left[OP_W-1:OP_W-2]};
        trial    = TRY_W'({root, 2'b01});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_left <= '0;
            rem       <= '0;
            root      <= '0;
            steps     <= '0;
            running   <= 1'b0;
            valid     <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                bits_left <= OP_W'(radicand);
                rem       <= '0;
                root      <= '0;
                steps     <= CNT_W'(K);
                running   <= 1'b1;
            end else if (running) begin
                bits_left <= {bits_left[OP_W-3:0], 2'b00};
                if (rem_next >= trial) begin
                    rem  <= REM_W'(rem_next - trial);
                    root <= {root[K-2:0], 1'b1};
                end else begin
                    rem  <= REM_W'(rem_next);
                    root <= {root[K-2:0], 1'b0};
                end
                steps <= steps - 1'b1;
                if (steps == CNT_W'(1)) begin
                    running <= 1'b0;
                    valid   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sobel_frame_engine.sv
module sobel_frame_engine
    import sobel_pkg::*;
#(
    parameter int COLS     = 160,
    parameter int ROWS     = 120,
    parameter int OUT_BASE = COLS * ROWS,
    parameter int ADDR_W   = $clog2(OUT_BASE + COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [PIX_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data
);
    localparam int COL_W = $clog2(COLS);
    localparam int IDX_W = $clog2(COLS * ROWS);

    eng_state_t       st, st_nx;
    logic [COL_W-1:0] col;
    logic [IDX_W-1:0] idx;
    scan_flags_t      flags;
    win_t             win;
    logic [SQ_W-1:0]  sumsq;
    logic [ROOT_W-1:0] root;
    logic             root_ok;
    logic             accept;
    logic [ADDR_W-1:0] here_addr;

    assign accept = (st == ST_IDLE) && start;

    sobel_scan #(.COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .IDX_W(IDX_W)) u_scan (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (st == ST_NEXT),
        .col   (col),
        .idx   (idx),
        .flags (flags)
    );

    sobel_window #(.COLS(COLS), .COL_W(COL_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .shift_en (st == ST_TAKE),
        .col      (col),
        .px       (rd_data),
        .win      (win)
    );

    sobel_grad u_grad (
        .win   (win),
        .sumsq (sumsq)
    );

    sobel_isqrt #(.IN_W(SQ_W), .K(ROOT_W)) u_root (
        .clk      (clk),
        .rst      (rst),
        .go       (st == ST_ROOT_GO),
        .radicand (sumsq),
        .root     (root),
        .valid    (root_ok)
    );

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:      if (start) st_nx = ST_FETCH;
            ST_FETCH:     st_nx = ST_TAKE;
            ST_TAKE:      st_nx = flags.on_edge    ? ST_EDGE_WR :
                                  flags.has_window ? ST_ROOT_GO : ST_NEXT;
            ST_EDGE_WR:   st_nx = flags.has_window ? ST_ROOT_GO : ST_NEXT;
            ST_ROOT_GO:   st_nx = ST_ROOT_WAIT;
            ST_ROOT_WAIT: if (root_ok) st_nx = ST_MAG_WR;
            ST_MAG_WR:    st_nx = ST_NEXT;
            ST_NEXT:      st_nx = flags.final_px ? ST_IDLE : ST_FETCH;
            default:      st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st <= st_nx;
            if (accept)
                done <= 1'b0;
            else if (st == ST_NEXT && flags.final_px)
                done <= 1'b1;
        end
    end

    always_comb begin
        busy      = (st != ST_IDLE);
        rd_en     = (st == ST_FETCH);
        rd_addr   = ADDR_W'(idx);
        here_addr = ADDR_W'(OUT_BASE) + ADDR_W'(idx);
        wr_en     = (st == ST_EDGE_WR) || (st == ST_MAG_WR);
        wr_addr   = (st == ST_MAG_WR) ? here_addr - ADDR_W'(COLS + 1) : here_addr;
        wr_data   = (st == ST_MAG_WR) ? clamp_root(root) : '0;
    end

endmodule

// File: rtl/sobel_frame_engine_chk.sv
module sobel_frame_engine_chk #(
    parameter int COLS     = 160,
    parameter int ROWS     = 120,
    parameter int OUT_BASE = COLS * ROWS,
    parameter int ADDR_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] SRC_END = ADDR_W'(COLS * ROWS);
    localparam logic [ADDR_W-1:0] OUT_LO  = ADDR_W'(OUT_BASE);
    localparam logic [ADDR_W-1:0] OUT_HI  = ADDR_W'(OUT_BASE + COLS * ROWS);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !rd_en && !wr_en));

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    assert_read_range_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr < SRC_END));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_done_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_en, 2));

    assert_write_range_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr >= OUT_LO && wr_addr < OUT_HI));

    assert_port_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

endmodule

bind sobel_frame_engine sobel_frame_engine_chk #(
    .COLS(COLS), .ROWS(ROWS), .OUT_BASE(OUT_BASE), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sobel_frame_engine_bench.sv
module sobel_frame_engine_bench;
    localparam int C  = 8;
    localparam int R  = 6;
    localparam int N  = C * R;
    localparam int OB = N;
    localparam int AW = $clog2(OB + N);
    localparam int MEM = OB + N;

    // columns: pattern kind, amplitude, expected result at probe (3,3)
    localparam int VEC [6][3] = '{
        '{0, 90, 0}, '{1, 40, 160}, '{2, 150, 255},
        '{3, 255, 0}, '{4, 0, 143}, '{5, 20, 84}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;

    logic [7:0] mem [0:MEM-1];
    int rcnt [0:MEM-1];
    int wcnt [0:MEM-1];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sobel_frame_engine #(.COLS(C), .ROWS(R), .OUT_BASE(OB), .ADDR_W(AW)) u_sobel_frame_engine (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        if (rd_en) begin
            if (int'(rd_addr) < MEM) begin
                rd_data <= mem[rd_addr];
                rcnt[rd_addr] = rcnt[rd_addr] + 1;
            end
        end
        if (wr_en) begin
            if (int'(wr_addr) < MEM) begin
                mem[wr_addr] <= wr_data;
                wcnt[wr_addr] = wcnt[wr_addr] + 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int pix(input int k, input int a, input int r, input int c);
        case (k)
            0: return a;
            1: return (c < 4) ? 0 : a;
            2: return (r < 3) ? 0 : a;
            3: return ((r + c) % 2 == 1) ? a : 0;
            4: return r * 16 + c * 8;
            default: return (r + c >= 6) ? a : 0;
        endcase
    endfunction

    function automatic int raw_mag(input int k, input int a, input int r, input int c);
        int gx, gy, s, q;
        gx = (pix(k,a,r-1,c+1) + 2*pix(k,a,r,c+1) + pix(k,a,r+1,c+1))
           - (pix(k,a,r-1,c-1) + 2*pix(k,a,r,c-1) + pix(k,a,r+1,c-1));
        gy = (pix(k,a,r-1,c-1) + 2*pix(k,a,r-1,c) + pix(k,a,r-1,c+1))
           - (pix(k,a,r+1,c-1) + 2*pix(k,a,r+1,c) + pix(k,a,r+1,c+1));
        s = gx * gx + gy * gy;
        q = 0;
        while ((q + 1) * (q + 1) <= s) q++;
        return q;
    endfunction

    task automatic run_frame(input int k, input int a, input int probe, input bit poke);
        bit was_done;
        bit finished;
        for (int i = 0; i < MEM; i++) begin
            mem[i] = (i < N) ? 8'(pix(k, a, i / C, i % C)) : 8'hA5;
            rcnt[i] = 0;
            wcnt[i] = 0;
        end
        was_done = done;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        if (was_done)
            chk(done == 1'b0, "R7", "done cleared by start", int'(done), 0);
        finished = 1'b0;
        for (int t = 0; t < 20000 && !finished; t++) begin
            if (poke && t == 30) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            finished = done;
        end
        chk(finished, "R7", "done reached", int'(finished), 1);
        chk(busy == 1'b0, "R7", "busy low with done", int'(busy), 0);
        for (int i = 0; i < N; i++) begin
            int r, c, m, e;
            r = i / C;
            c = i % C;
            chk(rcnt[i] == 1, "R3", "source reads", rcnt[i], 1);
            chk(wcnt[OB + i] == 1, poke ? "R2" : "R9", "result writes", wcnt[OB + i], 1);
            if (r == 0 || r == R - 1 || c == 0 || c == C - 1) begin
                chk(mem[OB + i] == 8'd0, "R6", "border pixel", int'(mem[OB + i]), 0);
            end else begin
                m = raw_mag(k, a, r, c);
                e = (m > 255) ? 255 : m;
                chk(int'(mem[OB + i]) == e, (m > 255) ? "R5" : "R4",
                    "interior pixel", int'(mem[OB + i]), e);
            end
        end
        for (int i = 0; i < OB; i++)
            chk(wcnt[i] == 0, "R8", "write outside result region", wcnt[i], 0);
        chk(int'(mem[OB + 3 * C + 3]) == probe, "R4", "probe vector", int'(mem[OB + 3 * C + 3]), probe);
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R7", "done held", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R1", "outputs in reset",
            int'({busy, done, rd_en, wr_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset", int'({busy, done}), 0);

        for (int v = 0; v < 6; v++)
            run_frame(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);

        // start pulse during a running frame is ignored
        run_frame(5, 20, 84, 1'b1);

        // reset in the middle of a frame
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R1", "mid-frame reset",
            int'({busy, done, rd_en, wr_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R1", "stays idle after reset", int'(busy), 0);
        run_frame(4, 0, 143, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule